// File: doc/BRIEF.md
# Connection Lookup CAM with Guarded Writes

This block holds a table of connection entries. Each entry lives at a local connection index (LCI), which is also its address. An entry holds a key made of a port number (PN), a VPI and a VCI, plus two flags: a valid flag and a path-point flag. Every entry is compared against a key in parallel, so one search covers the whole table. The result is the lowest LCI that matches, together with a code that tells apart no match, one match and several matches.

A controller drives one command at a time with a valid/busy/done handshake. Four commands exist:

- **Write** stores an entry at an LCI. It can be guarded against overwriting a live slot and against creating a duplicate key.
- **Read** returns the entry held at an LCI.
- **Search** looks up a key, with optional masking of key fields and a mode that finds free slots.
- **Configure** loads the 5-bit mode register.

Every command reports its outcome in a 3-bit status register.

Top module: `conn_cam`

## Requirements
- R1: After reset, busy, done, status and cfg are zero and every entry is invalid with all fields zero.
- R2: A command is accepted on a rising edge where cmd_valid is high and busy is low. Busy is high from the next cycle until the command completes. Done is high for exactly one cycle at completion, with busy low. A cmd_valid while busy has no effect on the table, cfg or results.
- R3: Read, configure and unguarded writes raise done two cycles after the accept edge, which is one cycle after busy rises. Search and guarded writes raise done one cycle later.
- R4: Status reads zero in the cycle after acceptance. At completion it holds {refused, code[1:0]}, with code 00 = no match, 01 = one match, 10 = several matches.
- R5: With cfg[0] and cfg[1] both clear, a write to an in-range LCI stores the key and both flags unconditionally and reports status 000.
- R6: With cfg[0] set (overwrite guard), a write whose target slot is valid is refused: the table is unchanged and status bit 2 is set.
- R7: With cfg[1] set (duplicate guard), a write whose key matches any valid entry is refused. Status bit 2 is set and the code field reports the single or multiple match.
- R8: Read returns the PN, VPI, VCI, valid and path-point flags of the addressed entry. Status code is 01 if that entry is valid and 00 otherwise.
- R9: Search reports the lowest matching LCI and that entry's two flags in sr_lci, sr_vld and sr_pip, with the match code in status. On no match these outputs are zero.
- R10: An entry whose path-point flag is set matches a key regardless of the key's VCI.
- R11: During search, cfg[2] set removes the VCI comparison and cfg[3] set removes the PN and VPI comparison.
- R12: During search, cfg[4] set makes only invalid entries candidates. When it is clear, only valid entries are candidates. Write duplicate checks always consider valid entries only.
- R13: Configure copies cmd_cfg to cfg, and cfg changes only at the completion of a configure command.
- R14: A write or read with an LCI at or beyond the table depth touches no entry. The write reports status bit 2 set. The read returns all zeros with status 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 write, 1 read, 2 search, 3 configure |
| cmd_lci | input | 14 | Entry index for write and read |
| cmd_pn | input | 4 | Key port number |
| cmd_vpi | input | 12 | Key VPI |
| cmd_vci | input | 16 | Key VCI |
| cmd_vld | input | 1 | Valid flag to write |
| cmd_pip | input | 1 | Path-point flag to write |
| cmd_cfg | input | 5 | Mode word for configure |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | {refused, match code} |
| rd_pn | output | 4 | Read-back PN |
| rd_vpi | output | 12 | Read-back VPI |
| rd_vci | output | 16 | Read-back VCI |
| rd_vld | output | 1 | Read-back valid flag |
| rd_pip | output | 1 | Read-back path-point flag |
| sr_lci | output | 14 | Search result index |
| sr_vld | output | 1 | Valid flag of the search result |
| sr_pip | output | 1 | Path-point flag of the search result |
| cfg | output | 5 | Mode register: [0] overwrite guard, [1] duplicate guard, [2] mask VCI, [3] mask PN/VPI, [4] free-slot search |

## Verification
Every command is driven across one rising edge, and the bench then samples on falling edges. On the first falling edge it expects busy high and status cleared. It then counts falling edges until done appears. That count must be 1 for read, configure and unguarded writes, and 2 for search and guarded writes. Result registers, status and cfg are checked on the same falling edge where done is first seen, which is the only cycle in which the completion is guaranteed. Table contents are checked later through read commands, so the effect of a refused write or an ignored request shows up at the ports.

// File: rtl/conn_cam.sv
module conn_cam #(
  parameter int DEPTH = 64,
  parameter int LCI_W = 14,
  parameter int PN_W  = 4,
  parameter int VPI_W = 12,
  parameter int VCI_W = 16,
  parameter int CFG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [LCI_W-1:0] cmd_lci,
  input  logic [PN_W-1:0]  cmd_pn,
  input  logic [VPI_W-1:0] cmd_vpi,
  input  logic [VCI_W-1:0] cmd_vci,
  input  logic             cmd_vld,
  input  logic             cmd_pip,
  input  logic [CFG_W-1:0] cmd_cfg,
  output logic             busy,
  output logic             done,
  output logic [2:0]       status,
  output logic [PN_W-1:0]  rd_pn,
  output logic [VPI_W-1:0] rd_vpi,
  output logic [VCI_W-1:0] rd_vci,
  output logic             rd_vld,
  output logic             rd_pip,
  output logic [LCI_W-1:0] sr_lci,
  output logic             sr_vld,
  output logic             sr_pip,
  output logic [CFG_W-1:0] cfg
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_SR = 2'd2, OP_CF = 2'd3;

  typedef enum logic [1:0] {IDLE, EVAL, FIN} st_t;
  st_t st;

  logic [1:0]       op_q;
  logic [LCI_W-1:0] lci_q;
  logic [PN_W-1:0]  pn_q;
  logic [VPI_W-1:0] vpi_q;
  logic [VCI_W-1:0] vci_q;
  logic             vld_q, pip_q;
  logic [CFG_W-1:0] ncfg_q;

  logic [PN_W-1:0]  t_pn  [DEPTH];
  logic [VPI_W-1:0] t_vpi [DEPTH];
  logic [VCI_W-1:0] t_vci [DEPTH];
  logic [DEPTH-1:0] t_vld, t_pip;

  logic [DEPTH-1:0] hit;
  logic [AW-1:0]    first;
  logic [1:0]       code, m_code_q;
  logic [AW-1:0]    m_idx_q;

  wire is_srch  = (op_q == OP_SR);
  wire guarded  = cfg[0] | cfg[1];
  wire in_range = (lci_q < LCI_W'(DEPTH));
  wire [AW-1:0] idx = lci_q[AW-1:0];
  wire want_vld = is_srch ? ~cfg[4] : 1'b1;
  wire skip_vci = is_srch & cfg[2];
  wire skip_pv  = is_srch & cfg[3];

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      hit[i] = (t_vld[i] == want_vld)
            && (skip_pv  || (t_pn[i] == pn_q && t_vpi[i] == vpi_q))
            && (skip_vci || t_pip[i] || t_vci[i] == vci_q);
    first = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (hit[i]) first = AW'(i);
  end

  assign code = (|(hit & (hit - 1'b1))) ? 2'b10 : (|hit) ? 2'b01 : 2'b00;

  wire refuse = ~in_range | (cfg[1] & (m_code_q != 2'b00)) | (cfg[0] & t_vld[idx]);
  wire wr_en  = (op_q == OP_WR) &&
                ((st == EVAL && !guarded && in_range) || (st == FIN && !refuse));

  assign busy = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_vld <= '0;
      t_pip <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        t_pn[i]  <= '0;
        t_vpi[i] <= '0;
        t_vci[i] <= '0;
      end
    end else if (wr_en) begin
      t_pn[idx]  <= pn_q;
      t_vpi[idx] <= vpi_q;
      t_vci[idx] <= vci_q;
      t_vld[idx] <= vld_q;
      t_pip[idx] <= pip_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      done <= 1'b0;
      status <= '0;
      cfg <= '0;
      op_q <= '0; lci_q <= '0; pn_q <= '0; vpi_q <= '0; vci_q <= '0;
      vld_q <= 1'b0; pip_q <= 1'b0; ncfg_q <= '0;
      m_code_q <= '0; m_idx_q <= '0;
      rd_pn <= '0; rd_vpi <= '0; rd_vci <= '0; rd_vld <= 1'b0; rd_pip <= 1'b0;
      sr_lci <= '0; sr_vld <= 1'b0; sr_pip <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (cmd_valid) begin
          op_q <= cmd_op; lci_q <= cmd_lci; pn_q <= cmd_pn; vpi_q <= cmd_vpi;
          vci_q <= cmd_vci; vld_q <= cmd_vld; pip_q <= cmd_pip; ncfg_q <= cmd_cfg;
          status <= '0;
          st <= EVAL;
        end
        EVAL: begin
          m_code_q <= code;
          m_idx_q  <= first;
          case (op_q)
            OP_WR: if (guarded) st <= FIN;
                   else begin
                     status <= {~in_range, 2'b00};
                     done <= 1'b1;
                     st <= IDLE;
                   end
            OP_RD: begin
              if (in_range) begin
                rd_pn <= t_pn[idx]; rd_vpi <= t_vpi[idx]; rd_vci <= t_vci[idx];
                rd_vld <= t_vld[idx]; rd_pip <= t_pip[idx];
                status <= {2'b00, t_vld[idx]};
              end else begin
                rd_pn <= '0; rd_vpi <= '0; rd_vci <= '0; rd_vld <= 1'b0; rd_pip <= 1'b0;
              end
              done <= 1'b1;
              st <= IDLE;
            end
            OP_SR: st <= FIN;
            default: begin
              cfg <= ncfg_q;
              done <= 1'b1;
              st <= IDLE;
            end
          endcase
        end
        FIN: begin
          if (op_q == OP_WR) begin
            status <= {refuse, cfg[1] ? m_code_q : 2'b00};
          end else begin
            status <= {1'b0, m_code_q};
            if (m_code_q != 2'b00) begin
              sr_lci <= LCI_W'(m_idx_q);
              sr_vld <= t_vld[m_idx_q];
              sr_pip <= t_pip[m_idx_q];
            end else begin
              sr_lci <= '0; sr_vld <= 1'b0; sr_pip <= 1'b0;
            end
          end
          done <= 1'b1;
          st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/conn_cam_sva.sv
module conn_cam_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       busy,
  input logic       done,
  input logic [2:0] status,
  input logic [4:0] cfg
);
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy);
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r3_bounded_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy);
  a_r4_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> (status == 3'b000));
  a_r13_cfg_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg) |-> done);
endmodule

bind conn_cam conn_cam_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy),
  .done(done), .status(status), .cfg(cfg)
);

// File: tb/sim_conn_cam.sv
`timescale 1ns/1ps
module sim_conn_cam;
  localparam int D = 64;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [13:0] cmd_lci = 0;
  logic [3:0] cmd_pn = 0;
  logic [11:0] cmd_vpi = 0;
  logic [15:0] cmd_vci = 0;
  logic cmd_vld = 0, cmd_pip = 0;
  logic [4:0] cmd_cfg = 0;
  logic busy, done, rd_vld, rd_pip, sr_vld, sr_pip;
  logic [2:0] status;
  logic [3:0] rd_pn;
  logic [11:0] rd_vpi;
  logic [15:0] rd_vci;
  logic [13:0] sr_lci;
  logic [4:0] cfg;

  conn_cam #(.DEPTH(D)) u0 (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [3:0] m_pn [D];
  logic [11:0] m_vpi [D];
  logic [15:0] m_vci [D];
  logic m_vld [D], m_pip [D];
  logic [4:0] m_cfg = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      finish_run();
    end
  end

  task automatic find(input bit srch, input logic [4:0] cf, input logic [3:0] pn,
                      input logic [11:0] vpi, input logic [15:0] vci,
                      output logic [1:0] code, output int idx);
    int n = 0;
    idx = 0;
    for (int i = D - 1; i >= 0; i--) begin
      bit h;
      h = (m_vld[i] == (srch ? !cf[4] : 1'b1))
          && ((srch && cf[3]) || (m_pn[i] == pn && m_vpi[i] == vpi))
          && ((srch && cf[2]) || m_pip[i] || m_vci[i] == vci);
      if (h) begin n++; idx = i; end
    end
    code = (n > 1) ? 2'b10 : (n == 1) ? 2'b01 : 2'b00;
  endtask

  task automatic run(input logic [1:0] op, input logic [13:0] lci, input logic [3:0] pn,
                     input logic [11:0] vpi, input logic [15:0] vci, input logic v,
                     input logic p, input logic [4:0] cf, output int lat);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_lci = lci; cmd_pn = pn; cmd_vpi = vpi;
    cmd_vci = vci; cmd_vld = v; cmd_pip = p; cmd_cfg = cf;
    @(negedge clk);
    cmd_valid = 0;
    chk("R2 busy after accept", 32'(busy), 1);
    chk("R4 status cleared", 32'(status), 0);
    lat = 0;
    while (!done && lat < 8) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic do_write(input logic [13:0] lci, input logic [3:0] pn, input logic [11:0] vpi,
                          input logic [15:0] vci, input logic v, input logic p);
    int lat, idx;
    logic [1:0] code;
    bit inr, guarded, ref_w;
    logic [2:0] exp_st;
    inr = lci < D;
    guarded = m_cfg[0] | m_cfg[1];
    find(0, m_cfg, pn, vpi, vci, code, idx);
    if (!guarded) begin
      ref_w = !inr;
      exp_st = {ref_w, 2'b00};
    end else begin
      ref_w = !inr || (m_cfg[1] && code != 0) || (m_cfg[0] && m_vld[lci[5:0]]);
      exp_st = {ref_w, m_cfg[1] ? code : 2'b00};
    end
    run(0, lci, pn, vpi, vci, v, p, 0, lat);
    chk("R3 write latency", lat, guarded ? 2 : 1);
    chk(!inr ? "R14 write status" : m_cfg[1] ? "R7 write status" :
        m_cfg[0] ? "R6 write status" : "R5 write status", 32'(status), 32'(exp_st));
    if (!ref_w) begin
      m_pn[lci] = pn; m_vpi[lci] = vpi; m_vci[lci] = vci; m_vld[lci] = v; m_pip[lci] = p;
    end
  endtask

  task automatic do_read(input logic [13:0] lci);
    int lat;
    bit inr = lci < D;
    run(1, lci, 0, 0, 0, 0, 0, 0, lat);
    chk("R3 read latency", lat, 1);
    if (inr) begin
      chk("R8 read key", {rd_pn, rd_vpi, rd_vci}, {m_pn[lci], m_vpi[lci], m_vci[lci]});
      chk("R8 read flags", {rd_vld, rd_pip}, {m_vld[lci], m_pip[lci]});
      chk("R8 read status", 32'(status), {2'b00, m_vld[lci]});
    end else begin
      chk("R14 read zero", {rd_pn, rd_vpi, rd_vci, rd_vld, rd_pip}, 0);
      chk("R14 read status", 32'(status), 0);
    end
  endtask

  task automatic do_search(input logic [3:0] pn, input logic [11:0] vpi, input logic [15:0] vci,
                           input string req);
    int lat, idx;
    logic [1:0] code;
    find(1, m_cfg, pn, vpi, vci, code, idx);
    run(2, 0, pn, vpi, vci, 0, 0, 0, lat);
    chk("R3 search latency", lat, 2);
    chk({req, " R9 search status"}, 32'(status), {1'b0, code});
    if (code != 0)
      chk({req, " R9 search result"}, {sr_lci, sr_vld, sr_pip}, {14'(idx), m_vld[idx], m_pip[idx]});
    else
      chk({req, " R9 search none"}, {sr_lci, sr_vld, sr_pip}, 0);
  endtask

  task automatic do_cfg(input logic [4:0] cf);
    int lat;
    run(3, 0, 0, 0, 0, 0, 0, cf, lat);
    chk("R3 config latency", lat, 1);
    chk("R13 config loaded", 32'(cfg), 32'(cf));
    m_cfg = cf;
  endtask

  initial begin
    void'($urandom(1234));
    for (int i = 0; i < D; i++) begin
      m_pn[i] = 0; m_vpi[i] = 0; m_vci[i] = 0; m_vld[i] = 0; m_pip[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset busy/done", {busy, done}, 0);
    chk("R1 reset status", 32'(status), 0);
    chk("R1 reset cfg", 32'(cfg), 0);
    do_read(0);
    do_read(63);
    do_cfg(5'b11100);
    do_search(0, 0, 0, "R1 R12 all free");

    do_cfg(0);
    do_write(3, 1, 7, 100, 1, 0);
    do_write(3, 2, 8, 200, 1, 0);
    do_read(3);
    do_write(9, 1, 5, 0, 1, 1);
    do_search(1, 5, 999, "R10 path point");
    do_write(12, 1, 5, 77, 1, 0);
    do_write(20, 1, 5, 77, 1, 0);
    do_search(1, 5, 77, "R9 multi lowest");
    do_write(70, 1, 1, 1, 1, 0);
    do_read(70);

    do_cfg(5'b00001);
    do_write(3, 4, 4, 4, 1, 0);
    do_read(3);
    do_write(4, 4, 4, 4, 1, 0);
    do_cfg(5'b00010);
    do_write(30, 1, 5, 77, 1, 0);
    do_read(30);
    do_write(31, 1, 5, 123, 1, 0);
    do_cfg(5'b00011);
    do_write(4, 9, 9, 9, 1, 0);
    do_write(40, 9, 9, 9, 1, 0);
    do_write(41, 9, 9, 9, 1, 0);
    do_write(41, 2, 8, 200, 1, 0);

    do_cfg(5'b00100);
    do_search(2, 8, 5, "R11 mask VCI");
    do_cfg(5'b01000);
    do_search(0, 0, 200, "R11 mask PN/VPI");
    do_cfg(5'b11100);
    do_search(0, 0, 0, "R12 free slot");

    do_cfg(0);
    begin
      int lat;
      run(2, 0, 1, 5, 77, 0, 0, 0, lat);
      chk("R2 search done", lat, 2);
    end
    @(negedge clk);
    cmd_valid = 1; cmd_op = 0; cmd_lci = 50; cmd_pn = 15; cmd_vpi = 15; cmd_vci = 15;
    cmd_vld = 1; cmd_pip = 1;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3; cmd_cfg = 5'b11111;
    cmd_valid = 0;
    begin
      int lat;
      lat = 0;
      while (!done && lat < 8) begin @(negedge clk); lat++; end
      m_pn[50] = 15; m_vpi[50] = 15; m_vci[50] = 15; m_vld[50] = 1; m_pip[50] = 1;
    end
    do_search(1, 5, 77, "R2 pre-ignore");
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2; cmd_pn = 1; cmd_vpi = 5; cmd_vci = 77;
    @(negedge clk);
    cmd_op = 0; cmd_lci = 51; cmd_pn = 6; cmd_vpi = 6; cmd_vci = 6; cmd_vld = 1;
    @(negedge clk);
    cmd_op = 3; cmd_cfg = 5'b11111;
    if (done) begin
      cmd_valid = 0;
    end else begin
      @(negedge clk);
      cmd_valid = 0;
    end
    chk("R2 cfg unchanged while busy", 32'(cfg), 0);
    @(negedge clk);
    do_read(51);
    chk("R2 ignored write", {rd_pn, rd_vld}, {m_pn[51], m_vld[51]});

    for (int n = 0; n < 400; n++) begin
      int k = $urandom_range(0, 9);
      if (k < 4)
        do_write(($urandom_range(0, 15) == 0) ? 14'($urandom_range(64, 16383)) : 14'($urandom_range(0, 63)),
                 4'($urandom_range(0, 1)), 12'($urandom_range(0, 1)), 16'($urandom_range(0, 3)),
                 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 4) == 0));
      else if (k < 6)
        do_read(14'($urandom_range(0, 70)));
      else if (k < 9)
        do_search(4'($urandom_range(0, 1)), 12'($urandom_range(0, 1)), 16'($urandom_range(0, 3)), "rand");
      else
        do_cfg(5'($urandom_range(0, 31)));
    end
    finish_run();
  end
endmodule